// File: doc/BRIEF.md
# Seconds Timer with Alarm

This block is an always-on seconds timer attached to a processor register bus. A slow-clock enable input marks each slow-clock period. A prescaler counts those periods and emits one tick after a programmable number of them. When the slow-clock frequency is programmed as the period count, the tick rate is 1 Hz. Each tick advances a free-running up-counter. Software can restart the counter but can never load it.

An alarm word is compared against the counter. When a tick moves the counter onto the alarm value, the block records an alarm event. Every tick also records an increment event. Both events are held in a status word that clears when it is read. Each event has an enable bit in the mode word, and the enabled events are combined onto one interrupt line.

Software uses the block like a wall clock. It keeps a base time elsewhere, adds the counter value to it, and moves the alarm when it changes the base. The counter runs from a slower clock domain, so two reads taken back to back may return different values.

Top module: `sec_timer`

## Requirements
- R1: After reset the mode word (offset 0x00) reads the reset period 0x00008000 with both enables clear, the alarm word (0x04) reads 0xFFFFFFFF, the value word (0x08) and the status word (0x0C) read 0, and `irq` is low.
- R2: Mode bits 15:0 hold a period P. The counter at 0x08 increases by exactly one for every P slow-clock enable pulses.
- R3: A period field of 0 gives a tick every 65536 slow-clock enable pulses.
- R4: Writing the mode word with bit 18 set clears both the counter and the prescaler phase, so the next tick comes a full P pulses later. Bit 18 always reads back as 0.
- R5: The alarm word is 32 bits wide and writable. Status bit 0 sets on the tick that moves the counter onto the alarm value.
- R6: Status bit 1 sets on every tick.
- R7: A read of the status word returns the flags as they stood before the read and clears them. A flag that sets in the same cycle as the read stays set afterwards.
- R8: Mode bit 16 enables status bit 0 and mode bit 17 enables status bit 1 onto `irq`. `irq` is high exactly when some set flag has its enable set.
- R9: Writes to the value word and to the status word change neither the counter nor the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | One-cycle pulse per slow-clock period |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt: enabled status flags ORed |

## Verification
Read data is registered. It is valid in the cycle after the read is accepted. The status clear caused by a read takes effect at that same clock edge. The counter and both flags update at the edge that samples the slow pulse completing the period. `irq` is combinational from the flag and enable registers, so it follows a flag change or a mode write within the same cycle. The bench drives every input on the falling edge and samples one falling edge after the rising edge that carries the effect. It also aligns a slow pulse with a status read in a single cycle, which checks that a newly set flag survives the read.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;
   // Word index taken from address bits 3:2
   typedef enum logic [1:0] {
      WSEL_MODE   = 2'd0,
      WSEL_ALARM  = 2'd1,
      WSEL_VALUE  = 2'd2,
      WSEL_STATUS = 2'd3
   } wsel_e;

   // Flag positions in the status word; enables sit PRE_W bits higher
   localparam int unsigned FLG_ALARM = 0;
   localparam int unsigned FLG_INC   = 1;
   localparam int unsigned NUM_FLG   = 2;
endpackage

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
   parameter int unsigned PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_en,
   input  logic             restart,
   input  logic [PRE_W-1:0] period,
   output logic             tick
);
   logic [PRE_W-1:0] phase_q;
   logic [PRE_W-1:0] last_phase;
   logic             at_last;

   // A period of zero wraps to all ones, giving 2**PRE_W pulses per tick
   assign last_phase = period - 1'b1;
   assign at_last    = (phase_q == last_phase);
   assign tick       = slow_en && at_last && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          phase_q <= '0;
      else if (restart)    phase_q <= '0;
      else if (slow_en)    phase_q <= at_last ? '0 : phase_q + 1'b1;
   end
endmodule

// File: rtl/sec_counter.sv
module sec_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] count_nx
);
   assign count_nx = count_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_q <= '0;
      else if (restart) count_q <= '0;
      else if (tick)    count_q <= count_nx;
   end
endmodule

// File: rtl/sec_alarm.sv
module sec_alarm #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             tick,
   input  logic [CNT_W-1:0] count_nx,
   output logic [CNT_W-1:0] alarm_q,
   output logic             hit
);
   // Reset value of all ones stands for "no alarm"
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     alarm_q <= '1;
      else if (wr_en) alarm_q <= wr_val;
   end

   assign hit = tick && (count_nx == alarm_q);
endmodule

// File: rtl/sec_status.sv
module sec_status #(
   parameter int unsigned NF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set,
   input  logic          rd_clr,
   input  logic [NF-1:0] enable,
   output logic [NF-1:0] flags_q,
   output logic          irq
);
   for (genvar i = 0; i < NF; i++) begin : g_flag
      // A set in the read cycle takes precedence over the clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags_q[i] <= 1'b0;
         else        flags_q[i] <= set[i] | (flags_q[i] & ~rd_clr);
      end
   end

   assign irq = |(flags_q & enable);
endmodule

// File: rtl/sec_timer.sv
module sec_timer #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned PRE_W     = 16,
   parameter int unsigned PRESC_RST = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_en,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   import sec_timer_pkg::*;

   localparam int unsigned IE_LO   = PRE_W;
   localparam int unsigned RST_BIT = PRE_W + NUM_FLG;

   // Elaboration-time parameter checks
   if (PRE_W < 1 || RST_BIT >= DATA_W) begin : g_bad_pre
      $error("sec_timer: PRE_W does not fit the mode word");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("sec_timer: CNT_W must be 1..DATA_W");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("sec_timer: ADDR_W must be at least 4");
   end
   if (PRESC_RST >= (64'd1 << PRE_W)) begin : g_bad_rst
      $error("sec_timer: PRESC_RST exceeds the period field");
   end

   // Address decode; wider buses require the upper bits to be zero
   logic in_range;
   if (ADDR_W > 4) begin : g_wide
      assign in_range = ~|bus_addr[ADDR_W-1:4];
   end else begin : g_narrow
      assign in_range = 1'b1;
   end

   wsel_e wsel;
   logic  wr_acc, rd_acc;
   logic  wr_mode, wr_alarm, rd_status;
   logic  restart;
   logic  unused_bits;

   assign wsel      = wsel_e'(bus_addr[3:2]);
   assign wr_acc    = bus_sel && bus_wr && in_range;
   assign rd_acc    = bus_sel && !bus_wr;
   assign wr_mode   = wr_acc && (wsel == WSEL_MODE);
   assign wr_alarm  = wr_acc && (wsel == WSEL_ALARM);
   assign rd_status = rd_acc && in_range && (wsel == WSEL_STATUS);
   assign restart   = wr_mode && bus_wdata[RST_BIT];
   assign unused_bits = ^{bus_addr[1:0], bus_wdata};

   // Mode register: period and interrupt enables; restart is a strobe
   logic [PRE_W-1:0]   period_q;
   logic [NUM_FLG-1:0] ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= PRE_W'(PRESC_RST);
         ie_q     <= '0;
      end else if (wr_mode) begin
         period_q <= bus_wdata[PRE_W-1:0];
         ie_q     <= bus_wdata[IE_LO +: NUM_FLG];
      end
   end

   logic             tick;
   logic [CNT_W-1:0] count_q, count_nx, alarm_q;
   logic             alarm_hit;
   logic [NUM_FLG-1:0] flag_set, flags_q;

   sec_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .slow_en (slow_en),
      .restart (restart),
      .period  (period_q),
      .tick    (tick)
   );

   sec_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .restart  (restart),
      .count_q  (count_q),
      .count_nx (count_nx)
   );

   sec_alarm #(.CNT_W(CNT_W)) u_alm (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_alarm),
      .wr_val   (bus_wdata[CNT_W-1:0]),
      .tick     (tick),
      .count_nx (count_nx),
      .alarm_q  (alarm_q),
      .hit      (alarm_hit)
   );

   always_comb begin
      flag_set            = '0;
      flag_set[FLG_ALARM] = alarm_hit;
      flag_set[FLG_INC]   = tick;
   end

   sec_status #(.NF(NUM_FLG)) u_sts (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (flag_set),
      .rd_clr  (rd_status),
      .enable  (ie_q),
      .flags_q (flags_q),
      .irq     (irq)
   );

   // Read path, registered
   logic [DATA_W-1:0] mode_word, rd_word;

   always_comb begin
      mode_word = '0;
      mode_word[PRE_W-1:0]        = period_q;
      mode_word[IE_LO +: NUM_FLG] = ie_q;
   end

   always_comb begin
      rd_word = '0;
      if (in_range) begin
         unique case (wsel)
            WSEL_MODE:   rd_word = mode_word;
            WSEL_ALARM:  rd_word = DATA_W'(alarm_q);
            WSEL_VALUE:  rd_word = DATA_W'(count_q);
            WSEL_STATUS: rd_word = DATA_W'(flags_q);
            default:     rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_acc) bus_rdata <= rd_word;
   end
endmodule

// File: rtl/sec_timer_chk.sv
module sec_timer_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned PRE_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              irq,
   input logic              tick,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  alarm,
   input logic [1:0]        flags,
   input logic [1:0]        ie
);
   logic mapped, wr_mode, wr_value, wr_status, rd_status;

   assign mapped    = (bus_addr >> 4) == '0;
   assign wr_mode   = bus_sel && bus_wr && mapped && bus_addr[3:2] == 2'd0;
   assign wr_value  = bus_sel && bus_wr && mapped && bus_addr[3:2] == 2'd2;
   assign wr_status = bus_sel && bus_wr && mapped && bus_addr[3:2] == 2'd3;
   assign rd_status = bus_sel && !bus_wr && mapped && bus_addr[3:2] == 2'd3;

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count) |-> (count == $past(count) + 1'b1) || (count == '0)); // R2

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && bus_wdata[PRE_W+2]) |=> (count == '0)); // R4

   AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (count + 1'b1 == alarm)) |=> flags[0]); // R5

   AST_INC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> flags[1]); // R6

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !tick) |=> (flags == 2'b00)); // R7

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((flags & ie) != 2'b00)); // R8

   AST_VALUE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_value && !tick) |=> (count == $past(count))); // R9

   AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && flags != 2'b00) |=> (flags != 2'b00)); // R9
endmodule

bind sec_timer sec_timer_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W),
   .PRE_W  (PRE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .tick      (tick),
   .count     (count_q),
   .alarm     (alarm_q),
   .flags     (flags_q),
   .ie        (ie_q)
);

// File: tb/sec_timer_test.sv
module sec_timer_test;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [3:0] A_MODE = 4'h0, A_ALARM = 4'h4, A_VALUE = 4'h8, A_STATUS = 4'hC;
   localparam logic [31:0] RESTART = 32'h0004_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_en = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sec_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_en   (slow_en),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   function automatic int unsigned ticks_for(int unsigned pulses, int unsigned p);
      return pulses / ((p == 0) ? 65536 : p);
   endfunction

   function automatic logic [31:0] flags_for(int unsigned t, int unsigned a);
      return {30'd0, t > 0, (a != 0) && (t >= a)};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr32(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd32(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic pulses(int unsigned n, bit gaps);
      for (int unsigned i = 0; i < n; i++) begin
         @(negedge clk);
         slow_en = 1'b1;
         @(negedge clk);
         slow_en = 1'b0;
         if (gaps) repeat ($urandom % 3) @(negedge clk);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, v0;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      check("R1 irq", {31'd0, irq}, 32'd0);
      rd32(A_MODE, d);   check("R1 mode", d, 32'h0000_8000);
      rd32(A_ALARM, d);  check("R1 alarm", d, 32'hFFFF_FFFF);
      rd32(A_VALUE, d);  check("R1 value", d, 32'd0);
      rd32(A_STATUS, d); check("R1 status", d, 32'd0);

      // R2 period 3, seven pulses give two ticks; R4 restart reads back 0
      wr32(A_MODE, RESTART | 32'd3);
      pulses(7, 1'b0);
      rd32(A_VALUE, d);  check("R2 value after 7 pulses P=3", d, 32'd2);
      rd32(A_MODE, d);   check("R4 restart bit reads 0", d, 32'd3);
      // R6 increment flag, R7 clear on read
      rd32(A_STATUS, d); check("R6 increment flag", d, 32'd2);
      rd32(A_STATUS, d); check("R7 cleared after read", d, 32'd0);

      // R4 restart clears the prescaler phase
      pulses(1, 1'b0);
      wr32(A_MODE, RESTART | 32'd3);
      pulses(2, 1'b0);
      rd32(A_VALUE, d);  check("R4 no early tick after restart", d, 32'd0);
      pulses(1, 1'b0);
      rd32(A_VALUE, d);  check("R4 first tick after restart", d, 32'd1);

      // R5 alarm on reaching 4
      wr32(A_MODE, RESTART | 32'd1);
      wr32(A_ALARM, 32'd4);
      rd32(A_ALARM, d);  check("R5 alarm readback", d, 32'd4);
      rd32(A_STATUS, d);
      pulses(3, 1'b0);
      rd32(A_STATUS, d); check("R5 no alarm before match", d, 32'd2);
      pulses(1, 1'b0);
      rd32(A_STATUS, d); check("R5 alarm at match", d, 32'd3);

      // R8 enables
      wr32(A_MODE, RESTART | 32'h0001_0002);
      wr32(A_ALARM, 32'd100);
      rd32(A_STATUS, d);
      pulses(2, 1'b0);
      check("R8 disabled increment keeps irq low", {31'd0, irq}, 32'd0);
      wr32(A_MODE, 32'h0002_0002);
      check("R8 enabled increment raises irq", {31'd0, irq}, 32'd1);
      rd32(A_STATUS, d);
      check("R8 irq drops after status read", {31'd0, irq}, 32'd0);

      // R7 flag set in the read cycle survives
      wr32(A_MODE, RESTART | 32'd1);
      rd32(A_STATUS, d);
      @(negedge clk);
      slow_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_STATUS;
      @(negedge clk);
      d = bus_rdata; slow_en = 1'b0; bus_sel = 1'b0;
      check("R7 read in set cycle returns old flags", d, 32'd0);
      rd32(A_STATUS, d); check("R7 flag survives same-cycle read", d, 32'd2);

      // R9 writes to value and status are ignored
      rd32(A_VALUE, v0);
      wr32(A_VALUE, 32'hDEAD_BEEF);
      rd32(A_VALUE, d);  check("R9 value write ignored", d, v0);
      wr32(A_STATUS, 32'h3);
      rd32(A_STATUS, d); check("R9 status write sets nothing", d, 32'd0);
      pulses(1, 1'b0);
      wr32(A_STATUS, 32'h0);
      rd32(A_STATUS, d); check("R9 status write clears nothing", d, 32'd2);

      // R3 period zero: 65536 pulses per tick
      wr32(A_MODE, RESTART);
      @(negedge clk) slow_en = 1'b1;
      repeat (65535) @(negedge clk);
      slow_en = 1'b0;
      rd32(A_VALUE, d);  check("R3 no tick at 65535 pulses", d, 32'd0);
      pulses(1, 1'b0);
      rd32(A_VALUE, d);  check("R3 tick at 65536 pulses", d, 32'd1);

      // Random mix: R2 R5 R6 R8
      for (int it = 0; it < 40; it++) begin
         int unsigned p = 1 + $urandom % 5;
         int unsigned a = 1 + $urandom % 8;
         int unsigned n = $urandom % 30;
         logic [1:0] ie = 2'($urandom % 4);
         int unsigned t;
         logic [31:0] ef;
         wr32(A_MODE, RESTART | {14'd0, ie, 16'(p)});
         wr32(A_ALARM, a);
         rd32(A_STATUS, d);
         pulses(n, 1'b1);
         t  = ticks_for(n, p);
         ef = flags_for(t, a);
         rd32(A_VALUE, d);  check("R2 random count", d, t);
         check("R8 random irq", {31'd0, irq}, {31'd0, |(ef[1:0] & ie)});
         rd32(A_STATUS, d); check("R5 R6 random flags", d, ef);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule